// File: doc/BRIEF.md
# Multi-CPU Interrupt Wakeup Notifier

This block sits between an interrupt source and a cluster of CPUs. When a pending interrupt of some category is announced, it marks a hard-interrupt request on every CPU and decides which CPUs get a wakeup kick. Every CPU reports a run state, a halted flag and three enable bits: external, I/O and machine-check. A running CPU is always kicked. A halted CPU is kicked only if its enable bit for the announced category is set. CPUs that are stopped or check-stopped get the request flag but no kick.

The request flag stays set until the CPU clears it with its own acknowledge line. The kick is a registered single-cycle pulse. The interrupt queues and the way a CPU takes the interrupt belong to other blocks. The CPU count is a parameter and defaults to 4.

Top module: `irq_wake_notifier`

## Requirements
- R1: On a clock edge where `notifyValid` is high, the bit of `hardReq` for every CPU is 1 from the next cycle on, whatever the CPU's state.
- R2: A CPU whose run-state code is 0 (stopped) or 1 (check-stop) gets no kick.
- R3: A CPU whose run-state code is 2 (operating) or 3 (load) and whose halted flag is 0 is kicked on every notify.
- R4: A halted CPU in code 2 or 3 is kicked only when the enable bit for the category is set. `notifyKind` bit 0 (service) uses `cpuExtEn`, bit 1 (I/O) uses `cpuIoEn`, and bit 2 (machine-check) uses `cpuMchkEn`.
- R5: When several `notifyKind` bits are set, only the lowest set bit picks the enable. Service wins over I/O, and I/O wins over machine-check.
- R6: When `notifyKind` is 000, a halted CPU in code 2 or 3 is kicked without looking at any enable bit.
- R7: A kick is high for exactly the one cycle that follows the notify edge. `kick` is never high in a cycle that does not follow a notify edge.
- R8: A set `hardReq` bit stays set until that CPU's `reqAck` is sampled high. It is then 0 from the next cycle, unless a notify is sampled on the same edge, in which case it stays 1.
- R9: While reset is held, and in the first cycle after reset, `hardReq` and `kick` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| notifyValid | input | 1 | Notify strobe, one cycle per event |
| notifyKind | input | 3 | Category bits: 0 service, 1 I/O, 2 machine-check |
| cpuRunState | input | 2*NUM_CPU | Per-CPU run-state code: 0 stopped, 1 check-stop, 2 operating, 3 load |
| cpuHalted | input | NUM_CPU | Per-CPU halted flag |
| cpuExtEn | input | NUM_CPU | Per-CPU external enable |
| cpuIoEn | input | NUM_CPU | Per-CPU I/O enable |
| cpuMchkEn | input | NUM_CPU | Per-CPU machine-check enable |
| reqAck | input | NUM_CPU | Per-CPU clear for the request flag |
| hardReq | output | NUM_CPU | Sticky hard-interrupt request per CPU |
| kick | output | NUM_CPU | Registered one-cycle wakeup pulse per CPU |

## Verification
Each CPU is driven into every run-state code, both running and halted, so that the stopped and check-stop cases can be told apart from the kicked cases. Halted CPUs get every combination of the three enable bits under each single category, under mixed category masks and under an empty mask. Each of these separates the priority of the enable choice from a plain OR of the enables. Acknowledges are applied alone, together with a notify, and in idle cycles, which shows whether clearing or setting wins. A long random run checks all of these against the reference model on every clock.

// File: rtl/wake_notify_pkg.sv
package wake_notify_pkg;

  typedef enum logic [1:0] {
    RUN_STOPPED   = 2'd0,
    RUN_CHECKSTOP = 2'd1,
    RUN_OPERATING = 2'd2,
    RUN_LOAD      = 2'd3
  } runState_e;

  localparam int KIND_W = 3;

  // strobes from control to datapath; exactly one gate is set
  typedef struct packed {
    logic notifyStb;
    logic gateExt;
    logic gateIo;
    logic gateMchk;
    logic gateNone;
  } wakeStrobe_t;

endpackage

// File: rtl/wake_notify_ctrl.sv
module wake_notify_ctrl
  import wake_notify_pkg::*;
(
  input  logic              notifyValid,
  input  logic [KIND_W-1:0] notifyKind,
  output wakeStrobe_t       strobe
);

  // lowest set category bit chooses which enable gates a halted CPU
  always_comb begin
    strobe = '0;
    strobe.notifyStb = notifyValid;
    if (notifyKind[0])      strobe.gateExt  = 1'b1;
    else if (notifyKind[1]) strobe.gateIo   = 1'b1;
    else if (notifyKind[2]) strobe.gateMchk = 1'b1;
    else                    strobe.gateNone = 1'b1;
  end

endmodule

// File: rtl/wake_notify_dp.sv
module wake_notify_dp
  import wake_notify_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wakeStrobe_t          strobe,
  input  logic [2*NUM_CPU-1:0] cpuRunState,
  input  logic [NUM_CPU-1:0]   cpuHalted,
  input  logic [NUM_CPU-1:0]   cpuExtEn,
  input  logic [NUM_CPU-1:0]   cpuIoEn,
  input  logic [NUM_CPU-1:0]   cpuMchkEn,
  input  logic [NUM_CPU-1:0]   reqAck,
  output logic [NUM_CPU-1:0]   hardReq,
  output logic [NUM_CPU-1:0]   kick
);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    runState_e state;
    logic      active;
    logic      enPick;
    logic      eligible;
    logic      reqQ;
    logic      kickQ;

    assign state  = runState_e'(cpuRunState[2*i +: 2]);
    assign active = (state == RUN_OPERATING) || (state == RUN_LOAD);

    always_comb begin
      enPick = 1'b0;
      unique case (1'b1)
        strobe.gateExt:  enPick = cpuExtEn[i];
        strobe.gateIo:   enPick = cpuIoEn[i];
        strobe.gateMchk: enPick = cpuMchkEn[i];
        default:         enPick = 1'b1;
      endcase
    end

    assign eligible = active && (!cpuHalted[i] || enPick);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        reqQ  <= 1'b0;
        kickQ <= 1'b0;
      end else begin
        kickQ <= strobe.notifyStb && eligible;
        if (strobe.notifyStb)  reqQ <= 1'b1;
        else if (reqAck[i])    reqQ <= 1'b0;
      end
    end

    assign hardReq[i] = reqQ;
    assign kick[i]    = kickQ;
  end

endmodule

// File: rtl/irq_wake_notifier.sv
module irq_wake_notifier
  import wake_notify_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 notifyValid,
  input  logic [KIND_W-1:0]    notifyKind,
  input  logic [2*NUM_CPU-1:0] cpuRunState,
  input  logic [NUM_CPU-1:0]   cpuHalted,
  input  logic [NUM_CPU-1:0]   cpuExtEn,
  input  logic [NUM_CPU-1:0]   cpuIoEn,
  input  logic [NUM_CPU-1:0]   cpuMchkEn,
  input  logic [NUM_CPU-1:0]   reqAck,
  output logic [NUM_CPU-1:0]   hardReq,
  output logic [NUM_CPU-1:0]   kick
);

  wakeStrobe_t strobe;

  wake_notify_ctrl ctrl_i (
    .notifyValid (notifyValid),
    .notifyKind  (notifyKind),
    .strobe      (strobe)
  );

  wake_notify_dp #(.NUM_CPU(NUM_CPU)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .cpuRunState (cpuRunState),
    .cpuHalted   (cpuHalted),
    .cpuExtEn    (cpuExtEn),
    .cpuIoEn     (cpuIoEn),
    .cpuMchkEn   (cpuMchkEn),
    .reqAck      (reqAck),
    .hardReq     (hardReq),
    .kick        (kick)
  );

endmodule

// File: rtl/irq_wake_notifier_chk.sv
module irq_wake_notifier_chk #(
  parameter int NUM_CPU = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 notifyValid,
  input logic [2:0]           notifyKind,
  input logic [2*NUM_CPU-1:0] cpuRunState,
  input logic [NUM_CPU-1:0]   cpuHalted,
  input logic [NUM_CPU-1:0]   cpuExtEn,
  input logic [NUM_CPU-1:0]   cpuIoEn,
  input logic [NUM_CPU-1:0]   cpuMchkEn,
  input logic [NUM_CPU-1:0]   reqAck,
  input logic [NUM_CPU-1:0]   hardReq,
  input logic [NUM_CPU-1:0]   kick
);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_chk
    p_req_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      notifyValid |=> hardReq[i]);

    p_idle_no_kick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (notifyValid && !cpuRunState[2*i+1]) |=> !kick[i]);

    p_running_kick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (notifyValid && cpuRunState[2*i+1] && !cpuHalted[i]) |=> kick[i]);

    p_io_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (notifyValid && notifyKind == 3'b010 && cpuHalted[i] && !cpuIoEn[i])
      |=> !kick[i]);

    p_service_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (notifyValid && notifyKind[0] && cpuHalted[i] && !cpuExtEn[i])
      |=> !kick[i]);

    p_kick_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kick[i] |-> $past(notifyValid));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hardReq[i] && !reqAck[i]) |=> hardReq[i]);

    p_req_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reqAck[i] && !notifyValid) |=> !hardReq[i]);
  end

endmodule

bind irq_wake_notifier irq_wake_notifier_chk #(.NUM_CPU(NUM_CPU)) chk_i (.*);

// File: tb/irq_wake_notifier_tb_top.sv
`timescale 1ns/1ps
module irq_wake_notifier_tb_top;

  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           notifyValid = 1'b0;
  logic [2:0]     notifyKind = '0;
  logic [2*N-1:0] cpuRunState = '0;
  logic [N-1:0]   cpuHalted = '0;
  logic [N-1:0]   cpuExtEn = '0;
  logic [N-1:0]   cpuIoEn = '0;
  logic [N-1:0]   cpuMchkEn = '0;
  logic [N-1:0]   reqAck = '0;
  logic [N-1:0]   hardReq;
  logic [N-1:0]   kick;

  int testsRun = 0;
  int testsFailed = 0;
  bit expReq[N];
  bit expKick[N];
  string kickTag[N];
  string reqTag[N];

  always #10 clk = ~clk;  // 50 MHz

  irq_wake_notifier #(.NUM_CPU(N)) dut_i (.*);

  task automatic checkBit(input string tag, input string what, input int cpu,
                          input bit act, input bit exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s cpu%0d actual=%0b expected=%0b", tag, what, cpu, act, exp);
    end
  endtask

  // reference model: next outputs from the inputs held at the coming edge
  task automatic step();
    for (int i = 0; i < N; i++) begin
      int  st;
      bit  en;
      bit  runnable;
      st = cpuRunState[2*i +: 2];
      runnable = (st == 2) || (st == 3);
      if (notifyKind[0]) en = cpuExtEn[i];
      else if (notifyKind[1]) en = cpuIoEn[i];
      else if (notifyKind[2]) en = cpuMchkEn[i];
      else en = 1'b1;
      if (!notifyValid) kickTag[i] = "R7";
      else if (!runnable) kickTag[i] = "R2";
      else if (!cpuHalted[i]) kickTag[i] = "R3";
      else if (notifyKind == 3'b000) kickTag[i] = "R6";
      else if (notifyKind inside {3'b011, 3'b101, 3'b110, 3'b111}) kickTag[i] = "R5";
      else kickTag[i] = "R4";
      expKick[i] = notifyValid && runnable && (!cpuHalted[i] || en);
      if (notifyValid) begin expReq[i] = 1'b1; reqTag[i] = "R1"; end
      else if (reqAck[i]) begin expReq[i] = 1'b0; reqTag[i] = "R8"; end
      else reqTag[i] = "R8";
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      checkBit(kickTag[i], "kick", i, kick[i], expKick[i]);
      checkBit(reqTag[i], "hardReq", i, hardReq[i], expReq[i]);
    end
    notifyValid = 1'b0;
    reqAck = '0;
  endtask

  task automatic setCpus(input logic [2*N-1:0] rs, input logic [N-1:0] h,
                         input logic [N-1:0] e, input logic [N-1:0] io,
                         input logic [N-1:0] m);
    cpuRunState = rs; cpuHalted = h; cpuExtEn = e; cpuIoEn = io; cpuMchkEn = m;
  endtask

  task automatic notify(input logic [2:0] k);
    notifyValid = 1'b1; notifyKind = k;
    step();
    step();  // idle cycle after: kick must drop (R7)
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin expReq[i] = 0; expKick[i] = 0; end
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin  // R9 during reset
      checkBit("R9", "hardReq", i, hardReq[i], 1'b0);
      checkBit("R9", "kick", i, kick[i], 1'b0);
    end
    rst_n = 1'b1;
    step();  // R9 first cycle after reset (idle)

    // all four run states, running (R2, R3, R1)
    setCpus({2'd3, 2'd2, 2'd1, 2'd0}, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    notify(3'b001);
    // acknowledges clear (R8)
    reqAck = 4'b0101; step();
    step();
    // halted, active: each category with varied enables (R4)
    setCpus({2'd2, 2'd3, 2'd2, 2'd3}, 4'b1111, 4'b0011, 4'b0101, 4'b1001);
    notify(3'b001);
    notify(3'b010);
    notify(3'b100);
    // priority with mixed masks (R5)
    notify(3'b011);
    notify(3'b110);
    notify(3'b101);
    notify(3'b111);
    // empty mask (R6)
    setCpus({2'd2, 2'd3, 2'd1, 2'd0}, 4'b1111, 4'b0000, 4'b0000, 4'b0000);
    notify(3'b000);
    // ack together with notify: set wins (R8)
    reqAck = 4'b1111; notifyValid = 1'b1; notifyKind = 3'b010; step();
    reqAck = 4'b1111; step();
    // random run
    for (int n = 0; n < 400; n++) begin
      cpuRunState = $urandom; cpuHalted = $urandom; cpuExtEn = $urandom;
      cpuIoEn = $urandom; cpuMchkEn = $urandom;
      notifyKind = $urandom; notifyValid = $urandom_range(0, 1);
      reqAck = $urandom;
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule